// File: doc/BRIEF.md
# Three-Source Interrupt Acknowledge Arbiter

This block collects interrupt requests from three classes of a two-channel serial controller (receive, transmit, and modem/timer) and settles which class a host acknowledge cycle refers to. Each class owns a programmable 7-bit match level. When the host raises its acknowledge input, the block compares the presented address code with the match level of every class that has a request pending. It grants the winning class, marks that class active, clears its request flag and reports the granted class.

A countdown timer is part of the block. The host loads it, and it decrements on a prescaled tick. When it expires, it raises a request in the modem/timer class. The interrupt output stays high while any class has a request that is not yet being serviced. During a transmit service the host can mark that no data was moved.

Top module: `irq_ack_arbiter`

## Requirements
- R1: After a synchronous active-low reset, all three level readbacks and all three status bytes read 0x00, and `irq` and `ack_valid` are 0.
- R2: A write with `cfg_we` high stores `cfg_wdata[6:0]` into the level selected by `cfg_sel` (0 receive, 1 transmit, 2 modem/timer; 3 is ignored). Readback bit 7 is always 0.
- R3: A pulse on `req_rx`, `req_tx` or `req_mdm` sets the request flag (status bit 7) of that class at the next clock edge. `irq` is 1 whenever any class has its request flag set and its active flag (status bit 6) clear.
- R4: On the first cycle of `iack` high, a pending class whose level equals `ack_addr` is granted. After that edge `ack_valid` is 1 for one cycle, `ack_class` carries the class code (0 receive, 1 transmit, 2 modem/timer), the class request flag is cleared and its active flag is set. The active flag clears at the first edge with `iack` low.
- R5: When several pending classes match the same address, receive wins over transmit, and transmit wins over modem/timer.
- R6: A class without a pending request is never granted, even if its level matches the address.
- R7: An acknowledge that matches no pending class produces no `ack_valid` and leaves every flag unchanged.
- R8: A timer load with a nonzero value starts a count that drops by one per `tmr_tick`. The tick that reaches zero sets the modem/timer request flag, and the count then stays at zero. A load of zero is ignored.
- R9: `tx_nodata` sets transmit status bit 3 only while the transmit class is active, and it is ignored otherwise. The flag clears at the next transmit grant. Transmit status bits 2:0 always read 0.
- R10: Holding `iack` high for several cycles yields exactly one grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Level register write strobe |
| cfg_sel | input | 2 | Level register select |
| cfg_wdata | input | 8 | Level write data |
| lvl_rx_rd | output | 8 | Receive level readback |
| lvl_tx_rd | output | 8 | Transmit level readback |
| lvl_mdm_rd | output | 8 | Modem/timer level readback |
| req_rx | input | 1 | Receive request pulse |
| req_tx | input | 1 | Transmit request pulse |
| req_mdm | input | 1 | Modem line request pulse |
| tmr_load | input | 1 | Timer load strobe |
| tmr_value | input | 8 | Timer load value |
| tmr_tick | input | 1 | Prescaled timer tick |
| tx_nodata | input | 1 | Host marks no data moved in transmit service |
| iack | input | 1 | Host acknowledge |
| ack_addr | input | 7 | Host address code for acknowledge |
| irq | output | 1 | Interrupt request to host |
| ack_valid | output | 1 | One-cycle grant indication |
| ack_class | output | 2 | Granted class code |
| stat_rx | output | 8 | Receive status (7 request, 6 active) |
| stat_tx | output | 8 | Transmit status (7 request, 6 active, 3 no data) |
| stat_mdm | output | 8 | Modem/timer status (7 request, 6 active) |

## Verification
The matching path is exercised with distinct levels per class, with identical levels on all three classes, and with an address that equals the level of a class that has no pending request. These patterns separate a correct compare from one that ignores the pending state or the priority order. A further pattern uses an address that matches nothing, which shows whether flags leak on a miss. The timer is loaded with a small count and ticked up to and past expiry, and a load of zero is also tried. A held acknowledge and a no-data mark given both inside and outside a transmit service cover the edge detection and the gating of the flag.

// File: rtl/irq_arb_pkg.sv
// Package: shared widths and class codes for the interrupt acknowledge arbiter.
// Assumes the class index order is also the tie-break priority (0 highest).
package irq_arb_pkg;
    localparam int NCLS  = 3;
    localparam int LVL_W = 7;
    localparam int CLS_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_RX  = 2'd0,
        CLS_TX  = 2'd1,
        CLS_MDM = 2'd2
    } cls_e;
endpackage

// File: rtl/irq_level_regs.sv
// Module: one match-level register per interrupt class.
// Assumes a select outside 0..NCLS-1 writes nothing; only bits LVL_W-1:0 are kept.
module irq_level_regs
    import irq_arb_pkg::*;
#(
    parameter int N = NCLS,
    parameter int W = LVL_W,
    parameter int SEL_W = CLS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [SEL_W-1:0]   sel,
    input  logic [W-1:0]       wdata,
    output logic [N-1:0][W-1:0] lvl
);
    for (genvar g = 0; g < N; g++) begin : g_lvl
        // Store the level for class g when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl[g] <= '0;
            else if (we && (sel == SEL_W'(g)))
                lvl[g] <= wdata;
        end
    end
endmodule

// File: rtl/irq_countdown.sv
// Module: countdown timer feeding the modem/timer class.
// Assumes tick is a one-cycle prescaled strobe; a zero load is ignored.
module irq_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt;
    logic         load_ok;

    // A load only counts when it carries a nonzero value.
    assign load_ok = load && (value != '0);

    // Load, then decrement once per tick, holding at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load_ok)
            cnt <= value;
        else if (tick && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    // Expiry fires on the tick that takes the count from one to zero.
    assign expire = tick && !load_ok && (cnt == W'(1));
endmodule

// File: rtl/irq_class_sel.sv
// Module: compares the acknowledge address with each pending class level
// and picks one winner, lowest index first. Purely combinational.
module irq_class_sel
    import irq_arb_pkg::*;
#(
    parameter int N = NCLS,
    parameter int W = LVL_W,
    parameter int CW = CLS_W
) (
    input  logic [N-1:0][W-1:0] lvl,
    input  logic [N-1:0]        pend,
    input  logic [W-1:0]        addr,
    output logic [N-1:0]        grant,
    output logic                hit,
    output logic [CW-1:0]       code
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = pend[g] && (lvl[g] == addr);
    end

    // Isolate the lowest set bit: fixed priority by class index.
    assign grant = eq & (~eq + 1'b1);
    assign hit   = |eq;

    // Encode the one-hot winner into a class code.
    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++)
            if (grant[i]) code = CW'(i);
    end
endmodule

// File: rtl/irq_ack_arbiter.sv
// Module: top of the three-class interrupt acknowledge arbiter.
// Holds the request/active flags, detects the start of an acknowledge,
// grants one pending class whose level matches, and drives irq.
// Assumes iack is synchronous to clk and held for the whole acknowledge.
module irq_ack_arbiter
    import irq_arb_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       lvl_rx_rd,
    output logic [7:0]       lvl_tx_rd,
    output logic [7:0]       lvl_mdm_rd,
    input  logic             req_rx,
    input  logic             req_tx,
    input  logic             req_mdm,
    input  logic             tmr_load,
    input  logic [TMR_W-1:0] tmr_value,
    input  logic             tmr_tick,
    input  logic             tx_nodata,
    input  logic             iack,
    input  logic [6:0]       ack_addr,
    output logic             irq,
    output logic             ack_valid,
    output logic [1:0]       ack_class,
    output logic [7:0]       stat_rx,
    output logic [7:0]       stat_tx,
    output logic [7:0]       stat_mdm
);
    logic [NCLS-1:0][LVL_W-1:0] lvl;
    logic [NCLS-1:0]            en, act, set_req, grant;
    logic                       hit, start, iack_q, tmr_exp, notx;
    logic [CLS_W-1:0]           code;
    logic                       unused_wdata_msb;

    assign unused_wdata_msb = cfg_wdata[7];

    irq_level_regs u_lvl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata[LVL_W-1:0]),
        .lvl   (lvl)
    );

    irq_countdown #(.W(TMR_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .value  (tmr_value),
        .tick   (tmr_tick),
        .expire (tmr_exp)
    );

    irq_class_sel u_sel (
        .lvl   (lvl),
        .pend  (en),
        .addr  (ack_addr),
        .grant (grant),
        .hit   (hit),
        .code  (code)
    );

    // Request sources per class; the timer shares the modem class.
    assign set_req = {req_mdm | tmr_exp, req_tx, req_rx};
    assign start   = iack && !iack_q;

    // Flag update: grant clears request and sets active; new requests win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en        <= '0;
            act       <= '0;
            iack_q    <= 1'b0;
            ack_valid <= 1'b0;
            ack_class <= '0;
        end else begin
            iack_q    <= iack;
            ack_valid <= start && hit;
            if (start && hit)
                ack_class <= code;
            for (int i = 0; i < NCLS; i++) begin
                en[i]  <= (en[i] && !(start && grant[i])) || set_req[i];
                act[i] <= iack && (act[i] || (start && grant[i]));
            end
        end
    end

    // Transmit no-data mark: only during a transmit service, cleared on grant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            notx <= 1'b0;
        else if (start && grant[CLS_TX])
            notx <= 1'b0;
        else if (tx_nodata && act[CLS_TX])
            notx <= 1'b1;
    end

    assign irq = |(en & ~act);

    assign lvl_rx_rd  = {1'b0, lvl[CLS_RX]};
    assign lvl_tx_rd  = {1'b0, lvl[CLS_TX]};
    assign lvl_mdm_rd = {1'b0, lvl[CLS_MDM]};

    assign stat_rx  = {en[CLS_RX],  act[CLS_RX],  6'b0};
    assign stat_tx  = {en[CLS_TX],  act[CLS_TX],  2'b0, notx, 3'b0};
    assign stat_mdm = {en[CLS_MDM], act[CLS_MDM], 6'b0};
endmodule

// File: rtl/irq_ack_arbiter_chk.sv
// Module: property checker for irq_ack_arbiter, attached by bind.
// Assumes only the top-level ports; no internal state is sampled.
module irq_ack_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       iack,
    input logic       irq,
    input logic       ack_valid,
    input logic [1:0] ack_class,
    input logic [7:0] lvl_rx_rd,
    input logic [7:0] lvl_tx_rd,
    input logic [7:0] lvl_mdm_rd,
    input logic [7:0] stat_rx,
    input logic [7:0] stat_tx,
    input logic [7:0] stat_mdm
);
    // R2: level readback msb is zero
    a_r2_lvl_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_rx_rd[7] && !lvl_tx_rd[7] && !lvl_mdm_rd[7]);

    // R3: an unserviced request drives irq
    a_r3_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_rx[7] && !stat_rx[6]) || (stat_tx[7] && !stat_tx[6])
         || (stat_mdm[7] && !stat_mdm[6])) |-> irq);

    // R4: a grant marks the granted class active
    a_r4_grant_active: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ((ack_class == 2'd0 && stat_rx[6]) ||
                       (ack_class == 2'd1 && stat_tx[6]) ||
                       (ack_class == 2'd2 && stat_mdm[6])));

    // R4: active flags drop once acknowledge is released
    a_r4_act_release: assert property (@(posedge clk) disable iff (!rst_n)
        !iack |=> (!stat_rx[6] && !stat_tx[6] && !stat_mdm[6]));

    // R7: a grant needs an acknowledge in the previous cycle
    a_r7_grant_needs_iack: assert property (@(posedge clk) disable iff (!rst_n)
        !iack |=> !ack_valid);

    // R10: one grant per acknowledge
    a_r10_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);

    // R9: reserved transmit status bits stay zero
    a_r9_tx_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        stat_tx[2:0] == 3'b0);
endmodule

bind irq_ack_arbiter irq_ack_arbiter_chk u_chk (.*);

// File: tb/irq_ack_arbiter_bench.sv
module irq_ack_arbiter_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [1:0] cfg_sel;
    logic [7:0] cfg_wdata;
    logic [7:0] lvl_rx_rd, lvl_tx_rd, lvl_mdm_rd;
    logic       req_rx, req_tx, req_mdm;
    logic       tmr_load;
    logic [7:0] tmr_value;
    logic       tmr_tick, tx_nodata, iack;
    logic [6:0] ack_addr;
    logic       irq, ack_valid;
    logic [1:0] ack_class;
    logic [7:0] stat_rx, stat_tx, stat_mdm;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ack_arbiter u_irq_ack_arbiter (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [7:0] act_v, logic [7:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        req_rx = 0; req_tx = 0; req_mdm = 0; tmr_load = 0; tmr_value = 0;
        tmr_tick = 0; tx_nodata = 0; iack = 0; ack_addr = 0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic wr_lvl(logic [1:0] s, logic [7:0] d);
        cfg_we = 1; cfg_sel = s; cfg_wdata = d; step();
        cfg_we = 0;
    endtask

    task automatic raise(logic r, logic t, logic m);
        req_rx = r; req_tx = t; req_mdm = m; step();
        req_rx = 0; req_tx = 0; req_mdm = 0;
    endtask

    // Starts an acknowledge; after return the grant edge has passed.
    task automatic ack_begin(logic [6:0] a);
        iack = 1; ack_addr = a; step();
    endtask

    task automatic ack_end();
        iack = 0; step();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 lvl_rx", lvl_rx_rd, 8'h00);
        chk("R1 lvl_tx", lvl_tx_rd, 8'h00);
        chk("R1 lvl_mdm", lvl_mdm_rd, 8'h00);
        chk("R1 stat_rx", stat_rx, 8'h00);
        chk("R1 stat_tx", stat_tx, 8'h00);
        chk("R1 stat_mdm", stat_mdm, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 ack_valid", {7'b0, ack_valid}, 8'h00);
    endtask

    task automatic t_levels();
        do_reset();
        wr_lvl(2'd0, 8'hFF);
        wr_lvl(2'd1, 8'h2A);
        wr_lvl(2'd2, 8'h91);
        wr_lvl(2'd3, 8'h55);
        chk("R2 rx msb dropped", lvl_rx_rd, 8'h7F);
        chk("R2 tx", lvl_tx_rd, 8'h2A);
        chk("R2 mdm msb dropped", lvl_mdm_rd, 8'h11);
    endtask

    task automatic t_basic_ack();
        do_reset();
        wr_lvl(2'd0, 8'h10); wr_lvl(2'd1, 8'h20); wr_lvl(2'd2, 8'h30);
        raise(0, 1, 0);
        chk("R3 tx request", stat_tx, 8'h80);
        chk("R3 irq high", {7'b0, irq}, 8'h01);
        ack_begin(7'h20);
        chk("R4 ack_valid", {7'b0, ack_valid}, 8'h01);
        chk("R4 ack_class tx", {6'b0, ack_class}, 8'h01);
        chk("R4 tx active", stat_tx, 8'h40);
        chk("R3 irq low while active", {7'b0, irq}, 8'h00);
        step();
        chk("R10 pulse ends", {7'b0, ack_valid}, 8'h00);
        ack_end();
        chk("R4 active cleared", stat_tx, 8'h00);
    endtask

    task automatic t_tie();
        do_reset();
        wr_lvl(2'd0, 8'h05); wr_lvl(2'd1, 8'h05); wr_lvl(2'd2, 8'h05);
        raise(1, 1, 1);
        ack_begin(7'h05);
        chk("R5 rx first", {6'b0, ack_class}, 8'h00);
        chk("R5 tx still pending", stat_tx, 8'h80);
        chk("R5 irq still high", {7'b0, irq}, 8'h01);
        ack_end();
        ack_begin(7'h05);
        chk("R5 tx second", {6'b0, ack_class}, 8'h01);
        ack_end();
        ack_begin(7'h05);
        chk("R5 mdm third", {6'b0, ack_class}, 8'h02);
        chk("R5 mdm active", stat_mdm, 8'h40);
        ack_end();
        chk("R5 irq cleared", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_not_pending();
        do_reset();
        wr_lvl(2'd0, 8'h01); wr_lvl(2'd1, 8'h02);
        raise(0, 1, 0);
        ack_begin(7'h01);
        chk("R6 no grant to idle rx", {7'b0, ack_valid}, 8'h00);
        chk("R6 rx untouched", stat_rx, 8'h00);
        chk("R6 tx untouched", stat_tx, 8'h80);
        ack_end();
        ack_begin(7'h02);
        chk("R6 tx granted", {6'b0, ack_class}, 8'h01);
        chk("R6 tx valid", {7'b0, ack_valid}, 8'h01);
        ack_end();
    endtask

    task automatic t_no_match();
        do_reset();
        wr_lvl(2'd0, 8'h11); wr_lvl(2'd1, 8'h12); wr_lvl(2'd2, 8'h13);
        raise(1, 1, 1);
        ack_begin(7'h09);
        chk("R7 no ack_valid", {7'b0, ack_valid}, 8'h00);
        chk("R7 rx flags", stat_rx, 8'h80);
        chk("R7 tx flags", stat_tx, 8'h80);
        chk("R7 mdm flags", stat_mdm, 8'h80);
        ack_end();
    endtask

    task automatic t_held_iack();
        do_reset();
        wr_lvl(2'd0, 8'h07); wr_lvl(2'd1, 8'h07);
        raise(1, 1, 0);
        ack_begin(7'h07);
        chk("R10 first grant", {7'b0, ack_valid}, 8'h01);
        step(); step(); step();
        chk("R10 no second grant", {7'b0, ack_valid}, 8'h00);
        chk("R10 tx still pending", stat_tx, 8'h80);
        ack_end();
    endtask

    task automatic t_timer();
        do_reset();
        tmr_load = 1; tmr_value = 8'd3; step();
        tmr_load = 0; tmr_tick = 1;
        step(); step();
        chk("R8 not yet expired", stat_mdm, 8'h00);
        step();
        chk("R8 expiry sets modem request", stat_mdm, 8'h80);
        chk("R8 irq on expiry", {7'b0, irq}, 8'h01);
        wr_lvl(2'd2, 8'h33);
        ack_begin(7'h33);
        ack_end();
        step(); step();
        chk("R8 count holds at zero", stat_mdm, 8'h00);
        tmr_tick = 0;
        do_reset();
        tmr_load = 1; tmr_value = 8'd0; step();
        tmr_load = 0; tmr_tick = 1;
        for (int i = 0; i < 5; i++) step();
        tmr_tick = 0;
        chk("R8 zero load ignored", stat_mdm, 8'h00);
    endtask

    task automatic t_nodata();
        do_reset();
        tx_nodata = 1; step(); tx_nodata = 0;
        chk("R9 ignored outside service", stat_tx, 8'h00);
        wr_lvl(2'd1, 8'h03);
        raise(0, 1, 0);
        ack_begin(7'h03);
        tx_nodata = 1; step(); tx_nodata = 0;
        chk("R9 set during service", stat_tx, 8'h48);
        ack_end();
        chk("R9 kept after release", stat_tx, 8'h08);
        raise(0, 1, 0);
        ack_begin(7'h03);
        chk("R9 cleared on next grant", stat_tx, 8'h40);
        ack_end();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_levels();
        t_basic_ack();
        t_tie();
        t_not_pending();
        t_no_match();
        t_held_iack();
        t_timer();
        t_nodata();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule